// File: doc/BRIEF.md
# Bus Cycle Wait-State and Ready Sequencer

This block stretches a processor bus cycle according to the settings of the chip select that is active for the cycle. A plain cycle runs through four clocks, T1 to T4. The sequencer can insert a programmed number of internal wait states between T3 and T4. It can also let an external ready line hold the cycle open. It raises an extend signal while the cycle is stretched and pulses a completion strobe in T4. It then returns to idle and waits for the next cycle start.

A cycle's settings are captured in the clock where the cycle starts. These settings are the wait-state code, the ready-required bit and the ready-source bit. Changes to them during the cycle have no effect. When ready is required, the internal waits always run to completion. Ready is sampled one cycle ahead of the last programmed wait, so a ready that is already high costs no extra time. A ready that is late holds the cycle open. Once it arrives, exactly one further wait follows before T4. The ready line can come from a free-running asynchronous pin, which passes through a two-flop synchronizer, or from a pin that is already synchronous to the clock.

Top module: `bus_wait_seq`

## Requirements
- R1: While reset is applied, and after it is released until a cycle is started, bus_extend and cyc_t4 are both low. A cyc_start seen during reset starts nothing.
- R2: Take the clock after the edge that accepts cyc_start as cycle 1. With zero waits and ready not required, cyc_t4 is high in cycle 4 and bus_extend is never high.
- R3: ws_code values 0, 1, 2 and 3 insert that many wait states, so cyc_t4 falls in cycle 4+N when ready is not required.
- R4: ws_code values 4, 5, 6 and 7 insert 5, 7, 9 and 15 wait states.
- R5: bus_extend is high in every cycle after cycle 3 up to the T4 cycle, and only then. cyc_t4 is high for one clock and is never high together with bus_extend. The sequencer is idle in the clock after T4.
- R6: With rdy_req=0, both ready pins are ignored and the cycle length depends only on ws_code.
- R7: With rdy_req=1, ready is sampled in cycle 3 when N is 0 or 1, and in cycle N+2 when N is 2 or more. If ready is high there, cyc_t4 falls in cycle N+4. Ready before that point never shortens the cycle.
- R8: With rdy_req=1 and ready low at the sample point, the cycle holds with bus_extend high until ready is seen in some cycle R. One more wait then follows, and cyc_t4 falls in cycle R+2.
- R9: rdy_sel=0 selects ardy_in through a two-flop synchronizer. A rise set up before the clock edge that ends cycle c counts as ready from cycle c+2. rdy_sel=1 selects srdy_in directly. The pin that is not selected is ignored.
- R10: ws_code, rdy_req and rdy_sel are captured with the accepted cyc_start. Changing them later in the cycle has no effect. A cyc_start while a cycle is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cyc_start | input | 1 | Starts a bus cycle when the sequencer is idle |
| ws_code | input | WS_BITS (3) | Wait-state code for the cycle |
| rdy_req | input | 1 | 1: external ready must be honoured |
| rdy_sel | input | 1 | 0: asynchronous ready pin, 1: synchronous ready pin |
| ardy_in | input | 1 | Asynchronous active-high ready |
| srdy_in | input | 1 | Synchronous active-high ready |
| bus_extend | output | 1 | High while the cycle is stretched past T3 |
| cyc_t4 | output | 1 | One-clock pulse in the final T4 clock |

## Verification
The hardest case to reach is a ready that arrives late on the asynchronous path. The outcome depends both on where the sample point falls and on the two-clock synchronizer delay. The stimulus raises the pin in a chosen cycle counted from the start, so a rise just after the sample point lands in the hold phase. A second case raises the pin during the internal waits ahead of the sample point, where it must not shorten the cycle. After every start, the bench scrambles the configuration inputs, holds the unselected ready pin high and pulses cyc_start again. A sequencer that does not capture its settings, or that reads the wrong pin, then changes the length of the cycle.

// File: rtl/bws_pkg.sv
package bws_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_T1,
    S_T2,
    S_T3,
    S_TW,
    S_HOLD,
    S_T4
  } seq_state_t;

  // Largest wait count reachable with a code of the given width
  function automatic int unsigned max_waits(input int unsigned bits);
    return (bits >= 3) ? 15 : ((1 << bits) - 1);
  endfunction

  // Extended code: 0..3 direct, 4..7 map to 5, 7, 9, 15
  function automatic int unsigned ws_map(input logic [2:0] code);
    case (code)
      3'd4:    return 5;
      3'd5:    return 7;
      3'd6:    return 9;
      3'd7:    return 15;
      default: return int'(code);
    endcase
  endfunction

endpackage

// File: rtl/bws_sync.sv
module bws_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/bws_decode.sv
module bws_decode
  import bws_pkg::*;
#(
  parameter int WS_BITS = 3,
  parameter int CNT_W   = 4
) (
  input  logic [WS_BITS-1:0] code,
  output logic [CNT_W-1:0]   waits
);
  generate
    if (WS_BITS >= 3) begin : g_ext
      assign waits = CNT_W'(ws_map(code[2:0]));
    end else begin : g_plain
      assign waits = CNT_W'(code);
    end
  endgenerate
endmodule

// File: rtl/bws_fsm.sv
module bws_fsm
  import bws_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] waits_in,
  input  logic             req_in,
  input  logic             sel_in,
  input  logic             ardy_s,
  input  logic             srdy,
  output logic             extend,
  output logic             t4,
  output logic [CNT_W-1:0] waits_q,
  output logic             req_q
);
  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             sel_q;
  logic             load, rem_en, rdy_ok, stall;

  assign load   = (state_q == S_IDLE) && start;
  assign rdy_ok = sel_q ? srdy : ardy_s;
  assign stall  = req_q && !rdy_ok;

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    rem_en  = 1'b0;
    case (state_q)
      S_IDLE: if (start) state_d = S_T1;
      S_T1:   state_d = S_T2;
      S_T2:   state_d = S_T3;
      S_T3: begin
        if (waits_q == '0) begin
          state_d = stall ? S_HOLD : S_T4;
        end else if (waits_q == CNT_W'(1)) begin
          state_d = stall ? S_HOLD : S_TW;
          rem_d   = CNT_W'(1);
          rem_en  = 1'b1;
        end else begin
          state_d = S_TW;
          rem_d   = waits_q;
          rem_en  = 1'b1;
        end
      end
      S_TW: begin
        if (rem_q == CNT_W'(1)) begin
          state_d = S_T4;
        end else if ((rem_q == CNT_W'(2)) && stall) begin
          state_d = S_HOLD;
        end else begin
          rem_d  = rem_q - CNT_W'(1);
          rem_en = 1'b1;
        end
      end
      S_HOLD: begin
        if (!stall) begin
          state_d = S_TW;
          rem_d   = CNT_W'(1);
          rem_en  = 1'b1;
        end
      end
      S_T4:    state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waits_q <= '0;
      req_q   <= 1'b0;
      sel_q   <= 1'b0;
    end else if (load) begin
      waits_q <= waits_in;
      req_q   <= req_in;
      sel_q   <= sel_in;
    end
  end

  assign extend = (state_q == S_TW) || (state_q == S_HOLD);
  assign t4     = (state_q == S_T4);
endmodule

// File: rtl/bus_wait_seq.sv
module bus_wait_seq
  import bws_pkg::*;
#(
  parameter int WS_BITS     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cyc_start,
  input  logic [WS_BITS-1:0] ws_code,
  input  logic               rdy_req,
  input  logic               rdy_sel,
  input  logic               ardy_in,
  input  logic               srdy_in,
  output logic               bus_extend,
  output logic               cyc_t4
);
  localparam int CNT_W = $clog2(max_waits(WS_BITS) + 1);

  logic             rst_meta_q, rst_sync_n;
  logic             ardy_s;
  logic [CNT_W-1:0] waits_dec;
  logic [CNT_W-1:0] cfg_waits;
  logic             cfg_req;

  // Reset asserts at once and releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  bws_sync #(.STAGES(SYNC_STAGES)) u_ardy_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (ardy_in),
    .q     (ardy_s)
  );

  bws_decode #(.WS_BITS(WS_BITS), .CNT_W(CNT_W)) u_decode (
    .code  (ws_code),
    .waits (waits_dec)
  );

  bws_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (cyc_start),
    .waits_in (waits_dec),
    .req_in   (rdy_req),
    .sel_in   (rdy_sel),
    .ardy_s   (ardy_s),
    .srdy     (srdy_in),
    .extend   (bus_extend),
    .t4       (cyc_t4),
    .waits_q  (cfg_waits),
    .req_q    (cfg_req)
  );
endmodule

// File: rtl/bus_wait_seq_chk.sv
module bus_wait_seq_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_start,
  input logic             bus_extend,
  input logic             cyc_t4,
  input logic [CNT_W-1:0] cfg_waits,
  input logic             cfg_req
);
  logic       active_q;
  logic [7:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!active_q) begin
      active_q <= cyc_start;
      cnt_q    <= cyc_start ? 8'd1 : 8'd0;
    end else begin
      active_q <= !cyc_t4;
      if (cnt_q != 8'hff) cnt_q <= cnt_q + 8'd1;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> (!bus_extend && !cyc_t4));

  // R5
  t4_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_t4 |=> !cyc_t4);

  // R5
  t4_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cyc_t4 && bus_extend));

  // R2
  min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_t4 |-> (cnt_q >= 8'd4));

  // R7
  waits_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_t4 |-> (cnt_q >= (8'(cfg_waits) + 8'd4)));

  // R6
  noready_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_t4 && !cfg_req) |-> (cnt_q == (8'(cfg_waits) + 8'd4)));
endmodule

bind bus_wait_seq bus_wait_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .cyc_start  (cyc_start),
  .bus_extend (bus_extend),
  .cyc_t4     (cyc_t4),
  .cfg_waits  (cfg_waits),
  .cfg_req    (cfg_req)
);

// File: tb/test_bus_wait_seq.sv
`timescale 1ns/1ps
module test_bus_wait_seq;
  logic       clk;
  logic       rst_n;
  logic       cyc_start;
  logic [2:0] ws_code;
  logic       rdy_req;
  logic       rdy_sel;
  logic       ardy_in;
  logic       srdy_in;
  logic       bus_extend;
  logic       cyc_t4;

  int checks = 0;
  int fails  = 0;

  bus_wait_seq i_bus_wait_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_start  (cyc_start),
    .ws_code    (ws_code),
    .rdy_req    (rdy_req),
    .rdy_sel    (rdy_sel),
    .ardy_in    (ardy_in),
    .srdy_in    (srdy_in),
    .bus_extend (bus_extend),
    .cyc_t4     (cyc_t4)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int exp_waits(input int code);
    case (code)
      4: return 5;
      5: return 7;
      6: return 9;
      7: return 15;
      default: return code;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // One bus cycle; rise = cycle in which the selected pin goes high (<=0: before start)
  task automatic run_case(input string tag, input int code, input bit req, input bit sel,
                          input int rise, input bit other_hi);
    int n, s, r, e, c, t4c, wc;
    n = exp_waits(code);
    s = (n <= 1) ? 3 : n + 2;
    r = (rise <= 0) ? 0 : (sel ? rise : rise + 2);
    if (!req || r <= s) e = n + 4;
    else                e = r + 2;

    @(negedge clk);
    ardy_in = sel ? other_hi : (rise <= 0);
    srdy_in = sel ? (rise <= 0) : other_hi;
    repeat (3) @(negedge clk);
    ws_code = 3'(code); rdy_req = req; rdy_sel = sel; cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0; ws_code = ~3'(code); rdy_req = ~req; rdy_sel = ~sel;
    c = 1; t4c = 0; wc = 0;
    while (t4c == 0 && c < 120) begin
      if (bus_extend) wc++;
      if (cyc_t4) t4c = c;
      if (c == 2) cyc_start = 1'b1;
      else        cyc_start = 1'b0;
      if (rise > 0 && c == rise) begin
        if (sel) srdy_in = 1'b1;
        else     ardy_in = 1'b1;
      end
      @(negedge clk);
      c++;
    end
    cyc_start = 1'b0;
    check(tag, "T4 cycle", t4c, e);
    check(tag, "extend cycles", wc, e - 4);
    check(tag, "idle after T4", int'({cyc_t4, bus_extend}), 0);
    ardy_in = 1'b0; srdy_in = 1'b0; ws_code = '0; rdy_req = 1'b0; rdy_sel = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; cyc_start = 1'b0; ws_code = '0; rdy_req = 1'b0; rdy_sel = 1'b0;
    ardy_in = 1'b0; srdy_in = 1'b0;
    repeat (3) @(negedge clk);
    cyc_start = 1'b1;
    @(negedge clk);
    check("R1", "outputs in reset", int'({cyc_t4, bus_extend}), 0);
    cyc_start = 1'b0;
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R1", "outputs after release", int'({cyc_t4, bus_extend}), 0);
    end
  endtask

  task automatic t_short_codes;
    run_case("R2", 0, 1'b0, 1'b1, 0, 1'b0);
    for (int k = 1; k < 4; k++) run_case("R3", k, 1'b0, 1'b1, 0, 1'b0);
  endtask

  task automatic t_long_codes;
    for (int k = 4; k < 8; k++) run_case("R4", k, 1'b0, 1'b0, 0, 1'b0);
  endtask

  task automatic t_ready_ignored;
    run_case("R6", 2, 1'b0, 1'b1, 0, 1'b1);
    run_case("R6", 3, 1'b0, 1'b0, 50, 1'b0);
    run_case("R5", 5, 1'b0, 1'b1, 0, 1'b0);
  endtask

  task automatic t_ready_on_time;
    run_case("R7", 2, 1'b1, 1'b1, 0, 1'b0);
    run_case("R7", 7, 1'b1, 1'b1, 17, 1'b0);
    run_case("R7", 0, 1'b1, 1'b1, 3, 1'b0);
    run_case("R7", 1, 1'b1, 1'b1, 0, 1'b0);
    run_case("R7", 5, 1'b1, 1'b0, 7, 1'b0);
  endtask

  task automatic t_ready_late;
    run_case("R8", 2, 1'b1, 1'b1, 6, 1'b0);
    run_case("R8", 0, 1'b1, 1'b1, 5, 1'b0);
    run_case("R8", 1, 1'b1, 1'b1, 4, 1'b0);
    run_case("R8", 7, 1'b1, 1'b1, 30, 1'b0);
  endtask

  task automatic t_ready_source;
    run_case("R9", 2, 1'b1, 1'b0, 3, 1'b0);
    run_case("R9", 3, 1'b1, 1'b0, 6, 1'b1);
    run_case("R9", 2, 1'b1, 1'b1, 5, 1'b1);
  endtask

  task automatic t_capture;
    run_case("R10", 6, 1'b0, 1'b0, 0, 1'b0);
    run_case("R10", 1, 1'b1, 1'b1, 9, 1'b1);
  endtask

  initial begin
    t_reset();
    t_short_codes();
    t_long_codes();
    t_ready_ignored();
    t_ready_on_time();
    t_ready_late();
    t_ready_source();
    t_capture();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule